// File: doc/BRIEF.md
# Joint Dual-Page Address Translation Buffer

This block is the address translation cache shared by the instruction fetch path and the data path. It holds a fixed number of entries, and a lookup compares every entry at the same time. Each entry covers a pair of neighbouring virtual pages, an even page and the odd page above it, and gives each page its own physical frame and its own attribute bits. Each entry also stores a size code, so an entry can map pages of any size from 4 KB up to 16 MB, in steps of a factor of four.

A lookup is purely combinational, from the virtual page number to the physical frame, so the result is ready in the same cycle as the cache access. Software-managed refill uses two other ports. The write port loads one indexed entry on a clock edge. The probe port reports which entry, if any, matches a given page pair. A write that would leave two live entries covering the same address is flagged while the write is presented.

Top module: `jtlb_xlate`

## Requirements
- R1: After reset every entry is empty. Every lookup reports `lk_hit`=0, `lk_valid`=0, `lk_dirty`=0, `lk_wback`=0, `lk_fault`=0 and `lk_pfn`=0, and every probe reports `pr_miss`=1 and `pr_idx`=0.
- R2: With size code 0 (4 KB pages), a lookup hits an entry whose stored pair number equals `lk_vpn[VPN_W-1:1]`. Bit `lk_vpn[0]` then picks the even frame (0) or the odd frame (1), and that frame is output on `lk_pfn`.
- R3: A lookup or probe matches only when its address-space ID equals the stored one, unless the entry's global bit is set. A set global bit matches any ID.
- R4: Size code c selects pages of 4 KB·4^c, and codes above MAX_SZ are treated as MAX_SZ. The pair compare ignores the low 2c bits of the pair number. `lk_vpn[2c]` picks the even or odd half. The low 2c bits of `lk_pfn` are copied from `lk_vpn`.
- R5: The flag fields are 3 bits wide: bit 0 valid, bit 1 dirty, bit 2 write-back. On a hit, `lk_valid`, `lk_dirty` and `lk_wback` show the flags of the selected half. On a miss all three are 0.
- R6: A hit whose selected half has its valid flag at 0 gives `lk_hit`=1, `lk_valid`=0 and `lk_fault`=1. A miss never raises `lk_fault`.
- R7: A probe with pair number `pr_vpn2` and ID `pr_asid` returns `pr_miss`=0 and the matching entry's index on `pr_idx`. With no match it returns `pr_miss`=1.
- R8: A write replaces every field of the indexed entry, so the mapping that entry held before no longer hits.
- R9: While `wr_en` is high, `wr_conflict` is 1 exactly when some other loaded entry would overlap the new one: the pair numbers agree above the larger of the two sizes, and the IDs are equal or either global bit is set. The entry being overwritten is never counted, and the write still takes place.
- R10: When several entries match, the lookup and the probe both use the lowest index.
- R11: A write takes effect at the clock edge on which `wr_en` is high. A lookup made during that cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, empties all entries |
| lk_vpn | input | VPN_W | Lookup virtual page number (4 KB units) |
| lk_asid | input | ASID_W | Lookup address-space ID |
| lk_hit | output | 1 | Some entry matches the lookup |
| lk_valid | output | 1 | Selected half is valid |
| lk_dirty | output | 1 | Selected half is writable |
| lk_wback | output | 1 | Selected half is write-back cacheable |
| lk_fault | output | 1 | Hit on an invalid half |
| lk_pfn | output | PFN_W | Translated physical frame number (4 KB units) |
| pr_vpn2 | input | VPN_W-1 | Probe pair number |
| pr_asid | input | ASID_W | Probe address-space ID |
| pr_miss | output | 1 | No entry matches the probe |
| pr_idx | output | IDX_W | Index of the matching entry |
| wr_en | input | 1 | Load entry `wr_idx` at the clock edge |
| wr_idx | input | IDX_W | Entry to load |
| wr_vpn2 | input | VPN_W-1 | New pair number |
| wr_size | input | 3 | New size code |
| wr_asid | input | ASID_W | New address-space ID |
| wr_global | input | 1 | New global bit |
| wr_pfn_even | input | PFN_W | Frame for the even page |
| wr_flags_even | input | 3 | Flags for the even page (bit 0 valid, bit 1 dirty, bit 2 write-back) |
| wr_pfn_odd | input | PFN_W | Frame for the odd page |
| wr_flags_odd | input | 3 | Flags for the odd page |
| wr_conflict | output | 1 | The presented write would overlap another loaded entry |

## Verification
The bench builds the block with eight entries and keeps the default widths: a 20-bit page number, a 20-bit frame number, 8-bit IDs and six size steps. With eight entries the highest index (7) can be loaded and probed in a few cycles, so every index bit is exercised. The widths leave room for the largest size code, so the 16 MB case and the clamping of code 7 are both tested. Overlapping writes are set up on purpose, which gives real double matches for the lowest-index rule and lets the conflict flag be checked for both a true overlap and a same-index overwrite.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Attribute bits kept for each half of an entry (bit 0 valid, 1 dirty, 2 write-back)
  typedef struct packed {
    logic wback;
    logic dirty;
    logic valid;
  } half_flags_t;

  // Limit a size code to the largest supported step
  function automatic int unsigned clamp_code(input logic [2:0] code,
                                             input int unsigned max_code);
    int unsigned c;
    c = {29'd0, code};
    return (c > max_code) ? max_code : c;
  endfunction

  // Number of 4 KB page-number bits that lie inside one page of this size
  function automatic int unsigned span_of(input logic [2:0] code,
                                          input int unsigned max_code);
    return 2 * clamp_code(code, max_code);
  endfunction

  // The larger of two spans, used when testing two entries for overlap
  function automatic int unsigned wider_span(input int unsigned a,
                                             input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_pkg::*;
#(
  parameter int unsigned VPN2_W = 19,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned MAX_SZ = 6
) (
  input  logic              used,
  input  logic [VPN2_W-1:0] e_vpn2,
  input  logic [2:0]        e_size,
  input  logic [ASID_W-1:0] e_asid,
  input  logic              e_global,
  input  logic [VPN2_W-1:0] q_vpn2,
  input  logic [ASID_W-1:0] q_asid,
  output logic              hit
);

  logic [VPN2_W-1:0] ignore_bits;
  logic              pair_eq;
  logic              asid_ok;

  assign ignore_bits = ~({VPN2_W{1'b1}} << span_of(e_size, MAX_SZ));
  assign pair_eq     = (((q_vpn2 ^ e_vpn2) & ~ignore_bits) == '0);
  assign asid_ok     = e_global || (q_asid == e_asid);
  assign hit         = used && pair_eq && asid_ok;

endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int unsigned N     = 48,
  parameter int unsigned IDX_W = 6
) (
  input  logic [N-1:0]     hit_vec,
  output logic [IDX_W-1:0] first_idx,
  output logic             any
);

  always_comb begin
    first_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) first_idx = IDX_W'(i);
    end
  end

  assign any = |hit_vec;

endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int unsigned N      = 48,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned VPN2_W = 19,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned PFN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [2:0]        wr_size,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_pfn_even,
  input  logic [2:0]        wr_flags_even,
  input  logic [PFN_W-1:0]  wr_pfn_odd,
  input  logic [2:0]        wr_flags_odd,
  output logic [N-1:0]      used_vec,
  output logic [VPN2_W-1:0] e_vpn2   [N],
  output logic [2:0]        e_size   [N],
  output logic [ASID_W-1:0] e_asid   [N],
  output logic              e_global [N],
  output logic [PFN_W-1:0]  e_pfn_ev [N],
  output logic [2:0]        e_fl_ev  [N],
  output logic [PFN_W-1:0]  e_pfn_od [N],
  output logic [2:0]        e_fl_od  [N]
);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic load;
    assign load = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        used_vec[g] <= 1'b0;
        e_vpn2[g]   <= '0;
        e_size[g]   <= '0;
        e_asid[g]   <= '0;
        e_global[g] <= 1'b0;
        e_pfn_ev[g] <= '0;
        e_fl_ev[g]  <= '0;
        e_pfn_od[g] <= '0;
        e_fl_od[g]  <= '0;
      end else if (load) begin
        used_vec[g] <= 1'b1;
        e_vpn2[g]   <= wr_vpn2;
        e_size[g]   <= wr_size;
        e_asid[g]   <= wr_asid;
        e_global[g] <= wr_global;
        e_pfn_ev[g] <= wr_pfn_even;
        e_fl_ev[g]  <= wr_flags_even;
        e_pfn_od[g] <= wr_pfn_odd;
        e_fl_od[g]  <= wr_flags_odd;
      end
    end
  end

endmodule

// File: rtl/jtlb_xlate.sv
module jtlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 48,
  parameter int unsigned VPN_W       = 20,
  parameter int unsigned PFN_W       = 20,
  parameter int unsigned ASID_W      = 8,
  parameter int unsigned MAX_SZ      = 6,
  localparam int unsigned IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int unsigned VPN2_W     = VPN_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic              lk_valid,
  output logic              lk_dirty,
  output logic              lk_wback,
  output logic              lk_fault,
  output logic [PFN_W-1:0]  lk_pfn,
  input  logic [VPN2_W-1:0] pr_vpn2,
  input  logic [ASID_W-1:0] pr_asid,
  output logic              pr_miss,
  output logic [IDX_W-1:0]  pr_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [2:0]        wr_size,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_pfn_even,
  input  logic [2:0]        wr_flags_even,
  input  logic [PFN_W-1:0]  wr_pfn_odd,
  input  logic [2:0]        wr_flags_odd,
  output logic              wr_conflict
);

  // Low page-number bits that can fall inside the largest page
  localparam int unsigned OFF_W = 2 * MAX_SZ;

  // Entry storage
  logic [NUM_ENTRIES-1:0] used_vec;
  logic [VPN2_W-1:0]      e_vpn2   [NUM_ENTRIES];
  logic [2:0]             e_size   [NUM_ENTRIES];
  logic [ASID_W-1:0]      e_asid   [NUM_ENTRIES];
  logic                   e_global [NUM_ENTRIES];
  logic [PFN_W-1:0]       e_pfn_ev [NUM_ENTRIES];
  logic [2:0]             e_fl_ev  [NUM_ENTRIES];
  logic [PFN_W-1:0]       e_pfn_od [NUM_ENTRIES];
  logic [2:0]             e_fl_od  [NUM_ENTRIES];

  tlb_store #(
    .N(NUM_ENTRIES), .IDX_W(IDX_W), .VPN2_W(VPN2_W),
    .ASID_W(ASID_W), .PFN_W(PFN_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2), .wr_size(wr_size),
    .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_pfn_even(wr_pfn_even), .wr_flags_even(wr_flags_even),
    .wr_pfn_odd(wr_pfn_odd), .wr_flags_odd(wr_flags_odd),
    .used_vec(used_vec), .e_vpn2(e_vpn2), .e_size(e_size), .e_asid(e_asid),
    .e_global(e_global), .e_pfn_ev(e_pfn_ev), .e_fl_ev(e_fl_ev),
    .e_pfn_od(e_pfn_od), .e_fl_od(e_fl_od)
  );

  // Parallel compare: lookup, probe and write overlap, one set per entry
  logic [NUM_ENTRIES-1:0] lk_match_vec;
  logic [NUM_ENTRIES-1:0] pr_match_vec;
  logic [NUM_ENTRIES-1:0] ov_vec;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    logic [VPN2_W-1:0] union_ign;
    logic              ov_asid;

    tlb_entry_match #(.VPN2_W(VPN2_W), .ASID_W(ASID_W), .MAX_SZ(MAX_SZ)) u_lk (
      .used(used_vec[g]), .e_vpn2(e_vpn2[g]), .e_size(e_size[g]),
      .e_asid(e_asid[g]), .e_global(e_global[g]),
      .q_vpn2(lk_vpn[VPN_W-1:1]), .q_asid(lk_asid), .hit(lk_match_vec[g])
    );

    tlb_entry_match #(.VPN2_W(VPN2_W), .ASID_W(ASID_W), .MAX_SZ(MAX_SZ)) u_pr (
      .used(used_vec[g]), .e_vpn2(e_vpn2[g]), .e_size(e_size[g]),
      .e_asid(e_asid[g]), .e_global(e_global[g]),
      .q_vpn2(pr_vpn2), .q_asid(pr_asid), .hit(pr_match_vec[g])
    );

    assign union_ign = ~({VPN2_W{1'b1}} << wider_span(span_of(wr_size, MAX_SZ),
                                                      span_of(e_size[g], MAX_SZ)));
    assign ov_asid   = wr_global || e_global[g] || (wr_asid == e_asid[g]);
    assign ov_vec[g] = used_vec[g] && (wr_idx != IDX_W'(g)) && ov_asid &&
                       (((wr_vpn2 ^ e_vpn2[g]) & ~union_ign) == '0);
  end

  assign wr_conflict = wr_en && (|ov_vec);

  // Lowest-index selection
  logic [IDX_W-1:0] lk_idx;
  logic             lk_any;
  logic [IDX_W-1:0] pr_first;
  logic             pr_any;

  tlb_first_hit #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_lk_enc (
    .hit_vec(lk_match_vec), .first_idx(lk_idx), .any(lk_any)
  );

  tlb_first_hit #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pr_enc (
    .hit_vec(pr_match_vec), .first_idx(pr_first), .any(pr_any)
  );

  assign pr_miss = !pr_any;
  assign pr_idx  = pr_any ? pr_first : '0;

  // Half selection and frame assembly for the winning entry
  int unsigned       hit_span;
  logic              odd_half;
  logic [PFN_W-1:0]  raw_pfn;
  half_flags_t       sel_fl;
  logic [OFF_W-1:0]  off_mask;
  logic [OFF_W-1:0]  sel_mask;

  always_comb begin
    hit_span = span_of(e_size[lk_idx], MAX_SZ);
    odd_half = lk_vpn[hit_span];
    raw_pfn  = odd_half ? e_pfn_od[lk_idx] : e_pfn_ev[lk_idx];
    sel_fl   = odd_half ? half_flags_t'(e_fl_od[lk_idx])
                        : half_flags_t'(e_fl_ev[lk_idx]);
    off_mask = ~({OFF_W{1'b1}} << hit_span);
  end

  assign sel_mask = lk_any ? off_mask : '0;
  assign lk_hit   = lk_any;
  assign lk_valid = lk_any && sel_fl.valid;
  assign lk_dirty = lk_any && sel_fl.dirty;
  assign lk_wback = lk_any && sel_fl.wback;
  assign lk_fault = lk_any && !sel_fl.valid;
  assign lk_pfn   = lk_any ? {raw_pfn[PFN_W-1:OFF_W],
                              (raw_pfn[OFF_W-1:0] & ~off_mask) |
                              (lk_vpn[OFF_W-1:0] & off_mask)}
                           : '0;

endmodule

// File: rtl/jtlb_xlate_chk.sv
module jtlb_xlate_chk #(
  parameter int unsigned N      = 48,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned PFN_W  = 20,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [VPN_W-1:0]  lk_vpn,
  input logic [ASID_W-1:0] lk_asid,
  input logic              lk_hit,
  input logic              lk_valid,
  input logic              lk_fault,
  input logic [PFN_W-1:0]  lk_pfn,
  input logic [VPN_W-2:0]  pr_vpn2,
  input logic [ASID_W-1:0] pr_asid,
  input logic              pr_miss,
  input logic [IDX_W-1:0]  pr_idx,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              wr_conflict,
  input logic [N-1:0]      used_vec,
  input logic [OFF_W-1:0]  sel_mask
);

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!lk_hit && pr_miss && (lk_pfn == '0)));                       // R1

  AST_OFFSET_FROM_VPN: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (((lk_pfn[OFF_W-1:0] ^ lk_vpn[OFF_W-1:0]) & sel_mask) == '0));        // R4

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (!lk_valid && !lk_fault));                                           // R6

  AST_PROBE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    ((lk_vpn[VPN_W-1:1] == pr_vpn2) && (lk_asid == pr_asid)) |-> (lk_hit == !pr_miss)); // R7

  AST_PROBE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !pr_miss |-> (32'(pr_idx) < N));                                                 // R7

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wr_idx) < N)) |=> used_vec[$past(wr_idx)]);                       // R8

  AST_CONFLICT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_conflict |-> wr_en);                                                          // R9

endmodule

bind jtlb_xlate jtlb_xlate_chk #(
  .N(NUM_ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W), .PFN_W(PFN_W),
  .ASID_W(ASID_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
  .lk_hit(lk_hit), .lk_valid(lk_valid), .lk_fault(lk_fault), .lk_pfn(lk_pfn),
  .pr_vpn2(pr_vpn2), .pr_asid(pr_asid), .pr_miss(pr_miss), .pr_idx(pr_idx),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_conflict(wr_conflict),
  .used_vec(used_vec), .sel_mask(sel_mask)
);

// File: tb/jtlb_xlate_test.sv
module jtlb_xlate_test;

  localparam int unsigned N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_hit, lk_valid, lk_dirty, lk_wback, lk_fault;
  logic [19:0] lk_pfn;
  logic [18:0] pr_vpn2 = '0;
  logic [7:0]  pr_asid = '0;
  logic        pr_miss;
  logic [2:0]  pr_idx;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [18:0] wr_vpn2 = '0;
  logic [2:0]  wr_size = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0;
  logic [19:0] wr_pfn_even = '0, wr_pfn_odd = '0;
  logic [2:0]  wr_flags_even = '0, wr_flags_odd = '0;
  logic        wr_conflict;

  always #5 clk = ~clk;

  jtlb_xlate #(.NUM_ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_valid(lk_valid),
    .lk_dirty(lk_dirty), .lk_wback(lk_wback), .lk_fault(lk_fault), .lk_pfn(lk_pfn),
    .pr_vpn2(pr_vpn2), .pr_asid(pr_asid), .pr_miss(pr_miss), .pr_idx(pr_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2), .wr_size(wr_size),
    .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_pfn_even(wr_pfn_even), .wr_flags_even(wr_flags_even),
    .wr_pfn_odd(wr_pfn_odd), .wr_flags_odd(wr_flags_odd),
    .wr_conflict(wr_conflict)
  );

  // Scoreboard item: kind 0 full lookup, 1 probe, 2 conflict flag, 3 lookup hit only
  typedef struct {
    int          kind;
    string       req;
    logic        hit;
    logic [19:0] pfn;
    logic [3:0]  vdwf;
    logic        miss;
    logic [2:0]  idx;
    logic        conf;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;

  // Monitor: results are combinational, sampled at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        case (e.kind)
          0: if ({lk_hit, lk_pfn, lk_valid, lk_dirty, lk_wback, lk_fault} !==
                 {e.hit, e.pfn, e.vdwf}) begin
               errors++;
               $display("FAIL %s lookup: got hit=%b pfn=%h vdwf=%b%b%b%b, expected hit=%b pfn=%h vdwf=%b",
                        e.req, lk_hit, lk_pfn, lk_valid, lk_dirty, lk_wback, lk_fault,
                        e.hit, e.pfn, e.vdwf);
             end
          1: if ({pr_miss, pr_idx} !== {e.miss, e.idx}) begin
               errors++;
               $display("FAIL %s probe: got miss=%b idx=%0d, expected miss=%b idx=%0d",
                        e.req, pr_miss, pr_idx, e.miss, e.idx);
             end
          2: if (wr_conflict !== e.conf) begin
               errors++;
               $display("FAIL %s conflict: got %b, expected %b", e.req, wr_conflict, e.conf);
             end
          default: if (lk_hit !== e.hit) begin
               errors++;
               $display("FAIL %s lookup during write: got hit=%b, expected hit=%b",
                        e.req, lk_hit, e.hit);
             end
        endcase
      end
    end
  end

  // Driver tasks: inputs change one time unit after the rising edge
  task automatic look(input logic [19:0] vpn, input logic [7:0] asid, input logic hit,
                      input logic [19:0] pfn, input logic [3:0] vdwf, input string req);
    exp_t e;
    @(posedge clk); #1;
    wr_en = 1'b0; lk_vpn = vpn; lk_asid = asid;
    e = '{kind: 0, req: req, hit: hit, pfn: pfn, vdwf: vdwf, miss: 1'b0, idx: '0, conf: 1'b0};
    exp_q.push_back(e);
  endtask

  task automatic probe(input logic [18:0] vpn2, input logic [7:0] asid,
                       input logic miss, input logic [2:0] idx, input string req);
    exp_t e;
    @(posedge clk); #1;
    wr_en = 1'b0; pr_vpn2 = vpn2; pr_asid = asid;
    e = '{kind: 1, req: req, hit: 1'b0, pfn: '0, vdwf: '0, miss: miss, idx: idx, conf: 1'b0};
    exp_q.push_back(e);
  endtask

  // Presents a write for one cycle; also looks up peek_vpn in that same cycle
  task automatic write(input logic [2:0] idx, input logic [18:0] vpn2, input logic [2:0] size,
                       input logic [7:0] asid, input logic glb,
                       input logic [19:0] pe, input logic [2:0] fe,
                       input logic [19:0] po, input logic [2:0] fo,
                       input logic conf, input logic [19:0] peek_vpn,
                       input logic peek_hit, input string req);
    exp_t e;
    @(posedge clk); #1;
    wr_en = 1'b1; wr_idx = idx; wr_vpn2 = vpn2; wr_size = size; wr_asid = asid;
    wr_global = glb; wr_pfn_even = pe; wr_flags_even = fe; wr_pfn_odd = po; wr_flags_odd = fo;
    lk_vpn = peek_vpn; lk_asid = asid;
    e = '{kind: 2, req: req, hit: 1'b0, pfn: '0, vdwf: '0, miss: 1'b0, idx: '0, conf: conf};
    exp_q.push_back(e);
    e = '{kind: 3, req: "R11", hit: peek_hit, pfn: '0, vdwf: '0, miss: 1'b0, idx: '0, conf: 1'b0};
    exp_q.push_back(e);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty after reset
    look(20'h12345, 8'd1, 1'b0, 20'h0, 4'b0000, "R1");
    probe(19'h091A2, 8'd1, 1'b1, 3'd0, "R1");

    // 4 KB pair at entry 0: even flags valid|dirty, odd flags valid|wback
    write(3'd0, 19'h091A2, 3'd0, 8'd1, 1'b0, 20'hAAAA0, 3'b011, 20'hBBBB1, 3'b101,
          1'b0, 20'h12344, 1'b0, "R9");
    look(20'h12344, 8'd1, 1'b1, 20'hAAAA0, 4'b1100, "R2 R5");
    look(20'h12345, 8'd1, 1'b1, 20'hBBBB1, 4'b1010, "R2 R5");
    look(20'h12345, 8'd2, 1'b0, 20'h0, 4'b0000, "R3");

    // Global entry 1, odd half invalid
    write(3'd1, 19'h20000, 3'd0, 8'd5, 1'b1, 20'h11110, 3'b001, 20'h0, 3'b000,
          1'b0, 20'h40000, 1'b0, "R9");
    look(20'h40000, 8'd9, 1'b1, 20'h11110, 4'b1000, "R3");
    look(20'h40001, 8'd9, 1'b1, 20'h0, 4'b0001, "R6");

    // 64 KB pair at the highest index
    write(3'd7, 19'h40000, 3'd2, 8'd3, 1'b0, 20'h22220, 3'b001, 20'h33330, 3'b111,
          1'b0, 20'h8000B, 1'b0, "R9");
    look(20'h8000B, 8'd3, 1'b1, 20'h2222B, 4'b1000, "R4");
    look(20'h8001C, 8'd3, 1'b1, 20'h3333C, 4'b1110, "R4");
    look(20'h80020, 8'd3, 1'b0, 20'h0, 4'b0000, "R4");
    probe(19'h4000F, 8'd3, 1'b0, 3'd7, "R7");

    // Size code 7 treated as the 16 MB step
    write(3'd6, 19'h60000, 3'd7, 8'd4, 1'b0, 20'h45000, 3'b001, 20'h46000, 3'b001,
          1'b0, 20'hC0ABC, 1'b0, "R9");
    look(20'hC0ABC, 8'd4, 1'b1, 20'h45ABC, 4'b1000, "R4");
    look(20'hC1ABC, 8'd4, 1'b1, 20'h46ABC, 4'b1000, "R4");

    // Overlapping write at entry 2 is flagged but performed
    write(3'd2, 19'h091A2, 3'd0, 8'd1, 1'b0, 20'hCCCC0, 3'b001, 20'hDDDD1, 3'b001,
          1'b1, 20'h12344, 1'b1, "R9");
    look(20'h12344, 8'd1, 1'b1, 20'hAAAA0, 4'b1100, "R10");
    probe(19'h091A2, 8'd1, 1'b0, 3'd0, "R10");

    // Rewrite entry 0 elsewhere: old mapping gone, new one seen after the edge
    write(3'd0, 19'h38000, 3'd0, 8'd1, 1'b0, 20'h77770, 3'b111, 20'h0, 3'b000,
          1'b0, 20'h70000, 1'b0, "R9");
    look(20'h70000, 8'd1, 1'b1, 20'h77770, 4'b1110, "R11");
    look(20'h12344, 8'd1, 1'b1, 20'hCCCC0, 4'b1000, "R8");
    probe(19'h091A2, 8'd1, 1'b0, 3'd2, "R8");

    // Same-index overwrite is never a conflict
    write(3'd2, 19'h091A2, 3'd0, 8'd1, 1'b0, 20'hEEEE0, 3'b001, 20'hDDDD1, 3'b001,
          1'b0, 20'h12344, 1'b1, "R9");
    look(20'h12344, 8'd1, 1'b1, 20'hEEEE0, 4'b1000, "R8");
    probe(19'h091A2, 8'd7, 1'b1, 3'd0, "R3");

    @(posedge clk); #1 wr_en = 1'b0;
    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule